// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a relative alarm with one-second resolution. Software writes the number of seconds still to go into a load register. Once counting is enabled, the remaining count drops by one on every one-second tick. When it reaches zero, a pending flag is raised. The flag then drives an interrupt output and a wake output, each through its own enable bit.

A zero count is an idle value: it never expires, so software may park the counter at zero while it reprograms the alarm. After an expiry the counter stays at zero until a new value is loaded. The pending flag is cleared by writing a one to it. An expiry in the same cycle as a clear wins, so no alarm is lost.

The register port is a simple single-cycle write strobe with a combinational read. The tick is a one-cycle pulse in the block's clock domain.

Top module: `countdown_alarm`

## Requirements
- R1: After reset the remaining count (offset 0x24), the load value (0x20) and the pending flag (0x30 bit 0) read 0, all enables (0x28, 0x2C, 0x50 bit 0) read 0, and irq and wake are low.
- R2: A write to offset 0x20 sets the remaining count to the written value in the next cycle, and 0x20 reads back the value last written.
- R3: While bit 0 of 0x28 is 1, each tick lowers a nonzero remaining count by exactly one. While that bit is 0, ticks leave the count unchanged.
- R4: A tick that takes the count from 1 to 0 sets the pending flag in the same clock edge. The count then stays 0 under further ticks, and the flag does not set again after a clear.
- R5: Loading 0 is idle: with counting enabled, ticks on a zero count never set the pending flag.
- R6: irq is high exactly when the pending flag and bit 0 of 0x2C are both 1.
- R7: wake is high exactly when the pending flag and bit 0 of 0x50 are both 1.
- R8: Writing 0x30 with bit 0 = 1 clears the pending flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R9: If an expiry and a clear write happen in the same cycle, the pending flag is 1 afterwards.
- R10: If a write to 0x20 and a tick happen in the same cycle, the written value is loaded and the tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt: pending and interrupt enable both set |
| wake | output | 1 | Wake request: pending and wake enable both set |

## Verification
On every cycle the assertions check the following:
- a count that changes without a load has moved down by exactly one;
- a zero count does not move unless a load occurs;
- the pending flag rises only after an expiry;
- an expiry always leaves the flag set, even when a clear arrives in the same cycle;
- irq and wake are never high without the flag.

The bench scenarios cover what a property cannot express in general:
- the exact number of ticks to expiry for a loaded value;
- load-over-tick priority at a chosen cycle;
- that a zero write to the status register leaves the flag as it was;
- the effect of each output mask as seen at the ports.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int OFS_LOAD   = 'h20;
  localparam int OFS_REMAIN = 'h24;
  localparam int OFS_RUN    = 'h28;
  localparam int OFS_IRQEN  = 'h2C;
  localparam int OFS_PEND   = 'h30;
  localparam int OFS_WAKE   = 'h50;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  remain,
  input  logic              pend,
  output logic [DATA_W-1:0] rdata,
  output logic              ld_we,
  output logic [CNT_W-1:0]  ld_val,
  output logic              run_en,
  output logic              irq_en,
  output logic              wake_en,
  output logic              clr_req
);
  import alarm_pkg::*;

  logic [CNT_W-1:0] load_q, load_d;
  logic             run_q, run_d, ie_q, ie_d, wk_q, wk_d;
  logic             sel_load, sel_run, sel_ie, sel_wk, sel_pend;

  always_comb begin
    sel_load = (addr == ADDR_W'(OFS_LOAD));
    sel_run  = (addr == ADDR_W'(OFS_RUN));
    sel_ie   = (addr == ADDR_W'(OFS_IRQEN));
    sel_wk   = (addr == ADDR_W'(OFS_WAKE));
    sel_pend = (addr == ADDR_W'(OFS_PEND));
    load_d = (we && sel_load) ? wdata[CNT_W-1:0] : load_q;
    run_d  = (we && sel_run)  ? wdata[0] : run_q;
    ie_d   = (we && sel_ie)   ? wdata[0] : ie_q;
    wk_d   = (we && sel_wk)   ? wdata[0] : wk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      wk_q   <= 1'b0;
    end else begin
      load_q <= load_d;
      run_q  <= run_d;
      ie_q   <= ie_d;
      wk_q   <= wk_d;
    end
  end

  always_comb begin
    ld_we   = we && sel_load;
    ld_val  = wdata[CNT_W-1:0];
    clr_req = we && sel_pend && wdata[0];
    run_en  = run_q;
    irq_en  = ie_q;
    wake_en = wk_q;
    rdata   = '0;
    if (sel_load)   rdata = DATA_W'(load_q);
    if (sel_emain()) rdata = DATA_W'(remain);
    if (sel_run)    rdata[0] = run_q;
    if (sel_ie)     rdata[0] = ie_q;
    if (sel_wk)     rdata[0] = wk_q;
    if (sel_pend)   rdata[0] = pend;
  end

  function automatic logic sel_emain();
    return addr == ADDR_W'(OFS_REMAIN);
  endfunction
endmodule

// File: rtl/alarm_counter.sv
module alarm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             tick,
  input  logic             run_en,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce, step;

  always_comb begin
    step   = tick && run_en && (cnt_q != '0);
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (ld_we) begin
      cnt_d  = ld_val;
      cnt_ce = 1'b1;
    end else if (step) begin
      cnt_d  = cnt_q - ONE;
      cnt_ce = 1'b1;
    end
    expire = !ld_we && step && (cnt_q == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/alarm_status.sv
module alarm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_req,
  input  logic irq_en,
  input  logic wake_en,
  output logic pend,
  output logic irq,
  output logic wake
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (expire)       pend_d = 1'b1;
    else if (clr_req) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
  assign irq  = pend_q & irq_en;
  assign wake = pend_q & wake_en;
endmodule

// File: rtl/countdown_alarm.sv
module countdown_alarm #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              wake
);
  logic [CNT_W-1:0] count_q, ld_val;
  logic ld_we, run_en, irq_en, wake_en, clr_req, expire, pend_q;

  alarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .remain(count_q), .pend(pend_q), .rdata(bus_rdata), .ld_we(ld_we),
    .ld_val(ld_val), .run_en(run_en), .irq_en(irq_en), .wake_en(wake_en),
    .clr_req(clr_req)
  );

  alarm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_val(ld_val), .tick(sec_tick),
    .run_en(run_en), .count(count_q), .expire(expire)
  );

  alarm_status u_stat (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr_req(clr_req),
    .irq_en(irq_en), .wake_en(wake_en), .pend(pend_q), .irq(irq), .wake(wake)
  );
endmodule

// File: rtl/countdown_alarm_chk.sv
module countdown_alarm_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count_q,
  input logic             ld_we,
  input logic             expire,
  input logic             pend_q,
  input logic             irq,
  input logic             wake
);
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ld_we) && count_q != $past(count_q)) |-> count_q == $past(count_q) - CNT_W'(1)); // R3
  AST_PEND_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(expire)); // R4
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count_q) == '0 && !$past(ld_we)) |-> count_q == '0); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend_q); // R6
  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> pend_q); // R7
  AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend_q); // R9
endmodule

bind countdown_alarm countdown_alarm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count_q(count_q), .ld_we(ld_we),
  .expire(expire), .pend_q(pend_q), .irq(irq), .wake(wake)
);

// File: tb/sim_countdown_alarm.sv
module sim_countdown_alarm;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wake;
  int          n_chk = 0;
  int          n_bad = 0;

  countdown_alarm u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wake(wake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h24, v); check("R1 remain", v, 0);
    rd(8'h20, v); check("R1 load", v, 0);
    rd(8'h30, v); check("R1 pend", v, 0);
    rd(8'h28, v); check("R1 run", v, 0);
    rd(8'h2C, v); check("R1 irqen", v, 0);
    rd(8'h50, v); check("R1 wakeen", v, 0);
    check("R1 irq", irq, 0); check("R1 wake", wake, 0);
  endtask

  task automatic t_load_hold;
    logic [31:0] v;
    wr(8'h20, 32'd5);
    rd(8'h20, v); check("R2 load readback", v, 5);
    rd(8'h24, v); check("R2 remain", v, 5);
    tick(2);
    rd(8'h24, v); check("R3 hold while disabled", v, 5);
  endtask

  task automatic t_countdown;
    logic [31:0] v;
    wr(8'h2C, 1); wr(8'h50, 1); wr(8'h28, 1);
    tick(1); rd(8'h24, v); check("R3 one step", v, 4);
    tick(3); rd(8'h24, v); check("R3 at one", v, 1);
    rd(8'h30, v); check("R4 not yet pending", v, 0);
    check("R6 irq low before", irq, 0);
    tick(1); rd(8'h30, v); check("R4 pending", v, 1);
    rd(8'h24, v); check("R4 zero", v, 0);
    check("R6 irq", irq, 1); check("R7 wake", wake, 1);
    tick(2); rd(8'h24, v); check("R4 stays zero", v, 0);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(8'h30, 0); rd(8'h30, v); check("R8 zero write ignored", v, 1);
    wr(8'h30, 1); rd(8'h30, v); check("R8 cleared", v, 0);
    check("R8 irq low", irq, 0);
    tick(2); rd(8'h30, v); check("R4 no refire", v, 0);
  endtask

  task automatic t_masks;
    logic [31:0] v;
    wr(8'h2C, 0); wr(8'h20, 1); tick(1);
    rd(8'h30, v); check("R6 pend set", v, 1);
    check("R6 irq masked", irq, 0); check("R7 wake on", wake, 1);
    wr(8'h50, 0); check("R7 wake masked", wake, 0);
    wr(8'h2C, 1); check("R6 irq unmasked", irq, 1);
    wr(8'h30, 1);
  endtask

  task automatic t_zero_idle;
    logic [31:0] v;
    wr(8'h20, 0); tick(3);
    rd(8'h30, v); check("R5 zero idle", v, 0);
    rd(8'h24, v); check("R5 count zero", v, 0);
  endtask

  task automatic t_race;
    logic [31:0] v;
    wr(8'h20, 1);
    @(negedge clk); sec_tick = 1'b1; bus_we = 1'b1; bus_addr = 8'h30; bus_wdata = 1;
    @(negedge clk); sec_tick = 1'b0; bus_we = 1'b0;
    rd(8'h30, v); check("R9 expiry beats clear", v, 1);
    wr(8'h30, 1);
  endtask

  task automatic t_load_prio;
    logic [31:0] v;
    wr(8'h20, 3);
    @(negedge clk); sec_tick = 1'b1; bus_we = 1'b1; bus_addr = 8'h20; bus_wdata = 7;
    @(negedge clk); sec_tick = 1'b0; bus_we = 1'b0;
    rd(8'h24, v); check("R10 load wins", v, 7);
    tick(1); rd(8'h24, v); check("R10 next step", v, 6);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_hold();
    t_countdown();
    t_clear();
    t_masks();
    t_zero_idle();
    t_race();
    t_load_prio();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule